// File: doc/BRIEF.md
# Differential Pulse-Width Output Accumulator

This block sits behind the column neurons of an analog time-domain vector-by-matrix engine. Every output has two complementary pulse lines, one for the positive half and one for the negative half of a differential column pair. A pulse rises when the sweep ramp on its column crosses threshold and stays high until the sweep window ends. Its width therefore carries the result. One clock, shared by all lanes, times the pulses. Each lane counts up while only its positive pulse is high and down while only its negative pulse is high. The result is a signed count that is wider than the output code.

The extra accumulator bits let the partial results of several layer selections be summed in place. The `accumulate` input tells the lane whether to keep its running sum when a new sweep window opens. A right shift then picks the bit window that forms the 4-bit output. The shifted value is clamped to the signed 4-bit range and passed through one of four selectable activation maps. The codes of all lanes appear side by side on a store bus.

Top module: `tdc_out_unit`

## Requirements
- R1: After reset every accumulator is zero, so with linear activation and shift 0 every output code is 0.
- R2: In each clock cycle a lane adds +1 when only its positive pulse is high, adds -1 when only its negative pulse is high, and adds 0 when both pulses are high or both are low.
- R3: The accumulator is a signed 6-bit value that saturates at +31 and -32. It never wraps.
- R4: In a cycle with `win_start` high and `accumulate` low, the lane discards its old sum and keeps only that cycle's step. With `accumulate` high, the sum carries across windows. Without `win_start` or `clear`, an idle lane holds its value.
- R5: `clear` zeroes every accumulator on the next edge. It takes priority over pulses and `win_start`.
- R6: `shift_sel` (0 to 3) shifts the accumulator right arithmetically, rounding toward minus infinity. The result is clamped to -8..7.
- R7: With `act_sel` = 0 (linear), the code is the clamped value in two's complement.
- R8: With `act_sel` = 1 (rectifier), negative clamped values give 0 and the others pass unchanged.
- R9: With `act_sel` = 2 (tanh), the code is the signed value round(7·tanh(v/4)), rounded half up.
- R10: With `act_sel` = 3 (sigmoid), the code is the unsigned value round(15/(1+e^(-v/2))), rounded half up.
- R11: Lanes are independent. The code of lane i sits on `out_data[4i+3:4i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock shared by all lanes |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Zero all accumulators |
| win_start | input | 1 | First cycle of a sweep window |
| accumulate | input | 1 | Keep the running sum across windows |
| pos_pulse | input | NUM_OUT | Positive-half pulses, one per lane |
| neg_pulse | input | NUM_OUT | Negative-half pulses, one per lane |
| shift_sel | input | SH_W | Right-shift amount of the output window |
| act_sel | input | 2 | Activation: 0 linear, 1 rectifier, 2 tanh, 3 sigmoid |
| out_data | output | 4*NUM_OUT | Packed output codes, lane 0 in the low bits |

## Verification
On every cycle, the assertions check the following:
- the accumulator stepping by exactly one for a lone pulse;
- holding when idle;
- sticking at either rail instead of wrapping;
- zeroing after `clear` or after a restart window with no pulse;
- sign rules tying the linear and rectifier codes to the accumulator.

The exact values of the tanh and sigmoid maps, the shift-then-clamp arithmetic, and multi-window sums that reach saturation can only be shown by the bench. It compares a behavioural model against every lane on every clock.

// File: rtl/tdc_out_pkg.sv
package tdc_out_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    ACT_LINEAR  = 2'd0,
    ACT_RELU    = 2'd1,
    ACT_TANH    = 2'd2,
    ACT_SIGMOID = 2'd3
  } act_mode_e;

  // round(7*tanh(v/4)), v in -8..7, signed result
  function automatic logic signed [CODE_W-1:0] tanh_map(input logic [CODE_W-1:0] v);
    case (v)
      4'h8, 4'h9: tanh_map = -4'sd7;
      4'hA, 4'hB: tanh_map = -4'sd6;
      4'hC:       tanh_map = -4'sd5;
      4'hD:       tanh_map = -4'sd4;
      4'hE:       tanh_map = -4'sd3;
      4'hF:       tanh_map = -4'sd2;
      4'h0:       tanh_map = 4'sd0;
      4'h1:       tanh_map = 4'sd2;
      4'h2:       tanh_map = 4'sd3;
      4'h3:       tanh_map = 4'sd4;
      4'h4:       tanh_map = 4'sd5;
      4'h5, 4'h6: tanh_map = 4'sd6;
      default:    tanh_map = 4'sd7;
    endcase
  endfunction

  // round(15/(1+exp(-v/2))), v in -8..7, unsigned result
  function automatic logic [CODE_W-1:0] sigmoid_map(input logic [CODE_W-1:0] v);
    case (v)
      4'h8, 4'h9: sigmoid_map = 4'd0;
      4'hA, 4'hB: sigmoid_map = 4'd1;
      4'hC:       sigmoid_map = 4'd2;
      4'hD:       sigmoid_map = 4'd3;
      4'hE:       sigmoid_map = 4'd4;
      4'hF:       sigmoid_map = 4'd6;
      4'h0:       sigmoid_map = 4'd8;
      4'h1:       sigmoid_map = 4'd9;
      4'h2:       sigmoid_map = 4'd11;
      4'h3:       sigmoid_map = 4'd12;
      4'h4:       sigmoid_map = 4'd13;
      4'h5, 4'h6: sigmoid_map = 4'd14;
      default:    sigmoid_map = 4'd15;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] apply_act(input act_mode_e mode,
                                                 input logic signed [CODE_W-1:0] v);
    case (mode)
      ACT_LINEAR:  apply_act = v;
      ACT_RELU:    apply_act = v[CODE_W-1] ? '0 : v;
      ACT_TANH:    apply_act = tanh_map(v);
      default:     apply_act = sigmoid_map(v);
    endcase
  endfunction

endpackage

// File: rtl/tdc_pair_decode.sv
module tdc_pair_decode (
  input  logic pos_in,
  input  logic neg_in,
  output logic step_up,
  output logic step_down
);
  // differential combine: only a lone half moves the count
  assign step_up   = pos_in & ~neg_in;
  assign step_down = neg_in & ~pos_in;
endmodule

// File: rtl/tdc_accum.sv
module tdc_accum #(
  parameter int ACC_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    restart,
  input  logic                    step_up,
  input  logic                    step_down,
  output logic signed [ACC_W-1:0] acc
);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] base_val;
  logic signed [ACC_W-1:0] acc_nxt;
  logic                    at_max;
  logic                    at_min;

  always_comb begin
    base_val = restart ? '0 : acc;
    at_max   = (base_val == ACC_MAX);
    at_min   = (base_val == ACC_MIN);
    acc_nxt  = base_val;
    if (step_up && !at_max)        acc_nxt = base_val + 1'b1;
    else if (step_down && !at_min) acc_nxt = base_val - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= '0;
    else            acc <= acc_nxt;
  end

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> acc == '0);

  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !restart && step_up && acc != ACC_MAX) |=> acc == ACC_W'($past(acc) + 1));

  assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !restart && step_down && acc != ACC_MIN) |=> acc == ACC_W'($past(acc) - 1));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !restart && !step_up && !step_down) |=> $stable(acc));

  assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && restart && !step_up && !step_down) |=> acc == '0);

  assert_no_wrap_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !restart && acc == ACC_MAX && !step_down) |=> acc == ACC_MAX);

  assert_no_wrap_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !restart && acc == ACC_MIN && !step_up) |=> acc == ACC_MIN);
endmodule

// File: rtl/tdc_post.sv
module tdc_post
  import tdc_out_pkg::*;
#(
  parameter int ACC_W = 6,
  parameter int SH_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [ACC_W-1:0] acc,
  input  logic [SH_W-1:0]         shift_amt,
  input  act_mode_e               mode,
  output logic [CODE_W-1:0]       code
);
  localparam int OMAX = (1 << (CODE_W-1)) - 1;
  localparam int OMIN = -(1 << (CODE_W-1));

  logic signed [ACC_W-1:0]  shifted;
  logic signed [CODE_W-1:0] clamped;

  always_comb begin
    shifted = acc >>> shift_amt;
    if (int'(shifted) > OMAX)      clamped = CODE_W'(OMAX);
    else if (int'(shifted) < OMIN) clamped = CODE_W'(OMIN);
    else                           clamped = shifted[CODE_W-1:0];
    code = apply_act(mode, clamped);
  end

  assert_linear_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ACT_LINEAR) |-> (code[CODE_W-1] == acc[ACC_W-1]));

  assert_relu_neg_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ACT_RELU && acc[ACC_W-1]) |-> code == '0);
endmodule

// File: rtl/tdc_out_unit.sv
module tdc_out_unit
  import tdc_out_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int ACC_W   = 6,
  parameter int SH_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      win_start,
  input  logic                      accumulate,
  input  logic [NUM_OUT-1:0]        pos_pulse,
  input  logic [NUM_OUT-1:0]        neg_pulse,
  input  logic [SH_W-1:0]           shift_sel,
  input  logic [1:0]                act_sel,
  output logic [NUM_OUT*CODE_W-1:0] out_data
);
  logic      restart;
  act_mode_e mode;

  assign restart = win_start & ~accumulate;
  assign mode    = act_mode_e'(act_sel);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
    logic                    up, down;
    logic signed [ACC_W-1:0] acc;
    logic [CODE_W-1:0]       code;

    tdc_pair_decode u_dec (
      .pos_in   (pos_pulse[i]),
      .neg_in   (neg_pulse[i]),
      .step_up  (up),
      .step_down(down)
    );

    tdc_accum #(.ACC_W(ACC_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .restart  (restart),
      .step_up  (up),
      .step_down(down),
      .acc      (acc)
    );

    tdc_post #(.ACC_W(ACC_W), .SH_W(SH_W)) u_post (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (acc),
      .shift_amt(shift_sel),
      .mode     (mode),
      .code     (code)
    );

    assign out_data[i*CODE_W +: CODE_W] = code;
  end
endmodule

// File: tb/tdc_out_unit_tb.sv
`timescale 1ns/1ps
module tdc_out_unit_tb;
  localparam int N   = 4;
  localparam int WIN = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         clear, win_start, accumulate;
  logic [N-1:0] pos_pulse, neg_pulse;
  logic [1:0]   shift_sel, act_sel;
  logic [N*4-1:0] out_data;

  int    model [N];
  int    pl [N];
  int    nl [N];
  int    n_checks = 0;
  int    n_fail   = 0;
  string scen     = "R1";

  always #2.5 clk = ~clk;

  tdc_out_unit #(.NUM_OUT(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .win_start(win_start),
    .accumulate(accumulate), .pos_pulse(pos_pulse), .neg_pulse(neg_pulse),
    .shift_sel(shift_sel), .act_sel(act_sel), .out_data(out_data)
  );

  function automatic int rnd(real r);
    return int'($floor(r + 0.5));
  endfunction

  function automatic int expect_code(int a, int sh, int act);
    int v;
    v = a >>> sh;
    if (v > 7) v = 7;
    if (v < -8) v = -8;
    case (act)
      0: return v & 15;
      1: return (v < 0) ? 0 : v;
      2: return rnd(7.0 * $tanh(real'(v) / 4.0)) & 15;
      default: return rnd(15.0 / (1.0 + $exp(-real'(v) / 2.0))) & 15;
    endcase
  endfunction

  function automatic string act_tag(int act);
    case (act)
      0: return "R7";
      1: return "R8";
      2: return "R9";
      default: return "R10";
    endcase
  endfunction

  // R11: each lane compared in its own 4-bit slice
  task automatic check_all();
    for (int i = 0; i < N; i++) begin
      int e, got;
      e   = expect_code(model[i], int'(shift_sel), int'(act_sel));
      got = int'(out_data[i*4 +: 4]);
      n_checks++;
      if (got != e) begin
        n_fail++;
        $display("FAIL %s/%s/R11 lane %0d: got %0d expected %0d (acc model %0d)",
                 scen, act_tag(int'(act_sel)), i, got, e, model[i]);
      end
    end
  endtask

  // advance model as the edge will, then check after it
  task automatic step();
    for (int i = 0; i < N; i++) begin
      int b, d, nv;
      b = (win_start && !accumulate) ? 0 : model[i];
      d = (pos_pulse[i] && !neg_pulse[i]) ? 1 : ((neg_pulse[i] && !pos_pulse[i]) ? -1 : 0);
      nv = b + d;
      if (nv > 31) nv = 31;
      if (nv < -32) nv = -32;
      model[i] = clear ? 0 : nv;
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic run_window(bit accu);
    accumulate = accu;
    for (int c = 0; c < WIN; c++) begin
      win_start = (c == 0);
      for (int i = 0; i < N; i++) begin
        pos_pulse[i] = (c >= WIN - pl[i]);
        neg_pulse[i] = (c >= WIN - nl[i]);
      end
      step();
    end
    win_start = 0;
    pos_pulse = '0;
    neg_pulse = '0;
  endtask

  task automatic set_lens(int p0, int p1, int p2, int p3, int n0, int n1, int n2, int n3);
    pl[0] = p0; pl[1] = p1; pl[2] = p2; pl[3] = p3;
    nl[0] = n0; nl[1] = n1; nl[2] = n2; nl[3] = n3;
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    rst_n = 0; clear = 0; win_start = 0; accumulate = 0;
    pos_pulse = '0; neg_pulse = '0; shift_sel = 0; act_sel = 0;
    for (int i = 0; i < N; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    scen = "R1";
    check_all();
    step();

    // R2: up, down, both-high cancel, mixed widths
    scen = "R2";
    set_lens(5, 0, 3, 7, 0, 4, 3, 2);
    run_window(0);
    step();

    // R4: sum carried across windows, then restart
    scen = "R4";
    set_lens(2, 1, 0, 4, 0, 0, 1, 0);
    run_window(1);
    run_window(1);
    set_lens(1, 0, 2, 0, 0, 3, 0, 0);
    run_window(0);
    step();

    // R3: drive to both rails and keep pushing
    scen = "R3";
    set_lens(16, 16, 0, 0, 0, 0, 16, 16);
    run_window(0);
    run_window(1);
    run_window(1);
    set_lens(0, 4, 4, 0, 0, 0, 0, 0);
    run_window(1);

    // R6: shift windows over large accumulator values
    scen = "R6";
    set_lens(16, 9, 0, 3, 0, 0, 13, 0);
    run_window(0);
    set_lens(16, 0, 0, 0, 0, 0, 16, 0);
    run_window(1);
    for (int s = 0; s < 4; s++) begin
      shift_sel = 2'(s);
      step();
    end
    shift_sel = 0;

    // R5: clear beats pulses and win_start
    scen = "R5";
    clear = 1; win_start = 1; accumulate = 1;
    pos_pulse = 4'b0101; neg_pulse = 4'b0010;
    step();
    clear = 0; win_start = 0; pos_pulse = '0; neg_pulse = '0;
    step();

    // R7..R10: all 16 clamped values through every activation
    for (int k = 0; k < 4; k++) begin
      scen = "R7-R10 sweep";
      for (int i = 0; i < N; i++) begin
        int v;
        v = -8 + 4 * k + i;
        pl[i] = (v > 0) ? v : 0;
        nl[i] = (v < 0) ? -v : 0;
      end
      run_window(0);
      for (int a = 0; a < 4; a++) begin
        act_sel = 2'(a);
        step();
      end
      act_sel = 0;
    end

    // R8/R9/R10 with shift: clamping before activation
    scen = "R6 act";
    set_lens(16, 0, 12, 0, 0, 16, 0, 5);
    run_window(0);
    for (int a = 0; a < 4; a++) begin
      act_sel = 2'(a);
      for (int s = 0; s < 4; s++) begin
        shift_sel = 2'(s);
        step();
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule